// File: doc/BRIEF.md
# Counterflow Weight-Stationary FIR Array

This block evaluates a K-tap finite impulse response filter on a linear chain of identical cells. Each cell holds one coefficient for the whole run. Input samples enter at the left end and move one cell to the right per clock. Partial sums are seeded as zeros at the right end and move one cell to the left per clock. Both streams are registered at every cell. Each time a sample and a sum are present at the same cell, the cell adds weight × sample into the sum. A sum that reaches the left end has seen every tap, so the finished result leaves on the sum path itself. No separate collection path or adder tree is needed.

Streams running in opposite directions close the gap between them at two cells per clock. For this reason the block accepts a sample only on every other cycle and seeds a zero sum on every other cycle. The phase of the seeding is chosen so that each sum meets exactly one window of K consecutive accepted samples. A valid bit travels with each stream, together with a completeness flag on each sum. Because of this, windows that are not yet full after reset, or that contain an empty slot, are never reported as results. A result is reported one clock after the sample that closes its window is accepted, no matter how long the chain is.

Top module: `cw_fir_array`

## Requirements
- R1: While reset is high and on the cycle after it, `res_valid` is 0. Reset also clears every coefficient to 0, so a run with no coefficients loaded gives valid results of value 0.
- R2: A write with `coef_we`=1 stores `coef_data` as coefficient index `coef_idx` (0..TAPS-1). A reported result equals the signed sum over j of coef[j]·x[s-TAPS+1+j], where x[s] is the most recent accepted sample and x[s-TAPS+1] is the oldest sample in the window.
- R3: Counting clock edges from 0 at the first edge after reset, a sample with `x_vld`=1 is accepted only on even edges. A sample offered on an odd edge has no effect on any result.
- R4: An even slot with `x_vld`=0 is an empty slot. No result is reported for a window that contains an empty slot, or for a window that began before reset ended. So the first TAPS-1 slots after reset give no result.
- R5: The result of a window is visible right after the edge that follows the acceptance of its last sample. That is one cycle after acceptance, for any TAPS.
- R6: `res_valid` is never high on two adjacent cycles. With every slot filled, once the first window is complete it is high on every even-edge cycle.
- R7: Products and sums are signed and kept at full precision in `2*DATA_W+clog2(TAPS)` bits. The most negative operands therefore give exact results.
- R8: The array seeds a zero partial sum at its right end on every other cycle, never on two adjacent cycles, in the phase that aligns each sum with one sample window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | clog2(TAPS) | Coefficient index to write |
| coef_data | input | DATA_W | Signed coefficient value |
| x_vld | input | 1 | Sample offered this cycle |
| x_data | input | DATA_W | Signed sample value |
| res_valid | output | 1 | A complete filter result is present |
| res_data | output | 2*DATA_W+clog2(TAPS) | Signed filter result |

## Verification
The bench sweeps four coefficient sets against four sample patterns and checks the output on every cycle. The patterns include runs where all operands sit at the negative extreme. If the coefficients were mapped to the cells in the wrong order, results would come out time-reversed. If the arithmetic were narrow or unsigned, the extreme runs would wrap. Runs with empty slots and with junk samples offered on odd edges expose a design that reports partial windows or lets off-phase samples into a sum. If the sum seeding were in the wrong phase, sums would skip samples, which shows up as wrong values in every run. The bench also checks on which cycle each result appears and that the output stays low on odd cycles, so a design with an extra register stage, or one that emits results back to back, fails the timing checks.

// File: rtl/cw_fir_pkg.sv
package cw_fir_pkg;

  function automatic int acc_width(input int data_w, input int taps);
    return 2 * data_w + $clog2(taps);
  endfunction

  function automatic int idx_width(input int taps);
    return (taps < 2) ? 1 : $clog2(taps);
  endfunction

endpackage

// File: rtl/cw_fir_seq.sv
module cw_fir_seq #(
  parameter int TAPS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic x_vld,
  output logic acc_v,
  output logic inj_v
);
  localparam logic INJ_PH = 1'((TAPS - 1) % 2);

  logic ph;

  always_ff @(posedge clk) begin
    if (rst) ph <= 1'b0;
    else     ph <= ~ph;
  end

  assign acc_v = x_vld & ~ph;
  assign inj_v = ~rst & (ph == INJ_PH);

  p_inj_off_r8: assert property (@(posedge clk) disable iff (rst)
    inj_v |=> !inj_v);
  p_inj_on_r8: assert property (@(posedge clk) disable iff (rst)
    !inj_v |=> inj_v);

endmodule

// File: rtl/cw_fir_cell.sv
module cw_fir_cell #(
  parameter int DATA_W  = 8,
  parameter int ACC_W   = 18,
  parameter int IDX_W   = 2,
  parameter int COEF_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              coef_we,
  input  logic [IDX_W-1:0]  coef_idx,
  input  logic [DATA_W-1:0] coef_data,
  input  logic [DATA_W-1:0] x_in,
  input  logic              x_in_v,
  input  logic [ACC_W-1:0]  y_in,
  input  logic              y_in_v,
  input  logic              y_in_c,
  output logic [DATA_W-1:0] x_out,
  output logic              x_out_v,
  output logic [ACC_W-1:0]  y_out,
  output logic              y_out_v,
  output logic              y_out_c
);
  localparam int PROD_W = 2 * DATA_W;

  logic signed [DATA_W-1:0] w;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic                     meet;

  always_ff @(posedge clk) begin
    if (rst)
      w <= '0;
    else if (coef_we && coef_idx == IDX_W'(COEF_ID))
      w <= coef_data;
  end

  assign prod     = w * $signed(x_in);
  assign prod_ext = ACC_W'(prod);
  assign meet     = x_in_v & y_in_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_out   <= '0;
      x_out_v <= 1'b0;
      y_out   <= '0;
      y_out_v <= 1'b0;
      y_out_c <= 1'b0;
    end else begin
      x_out   <= x_in;
      x_out_v <= x_in_v;
      y_out_v <= y_in_v;
      y_out_c <= y_in_v & y_in_c & x_in_v;
      y_out   <= meet ? (y_in + prod_ext) : y_in;
    end
  end

  p_cmpl_needs_x_r4: assert property (@(posedge clk) disable iff (rst)
    y_out_c |-> $past(x_in_v));

endmodule

// File: rtl/cw_fir_array.sv
module cw_fir_array
  import cw_fir_pkg::*;
#(
  parameter  int TAPS   = 4,
  parameter  int DATA_W = 8,
  localparam int IDX_W  = idx_width(TAPS),
  localparam int ACC_W  = acc_width(DATA_W, TAPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              coef_we,
  input  logic [IDX_W-1:0]  coef_idx,
  input  logic [DATA_W-1:0] coef_data,
  input  logic              x_vld,
  input  logic [DATA_W-1:0] x_data,
  output logic              res_valid,
  output logic [ACC_W-1:0]  res_data
);
  logic acc_v;
  logic inj_v;

  logic [DATA_W-1:0] xs  [TAPS+1];
  logic              xsv [TAPS+1];
  logic [ACC_W-1:0]  ys  [TAPS+1];
  logic              ysv [TAPS+1];
  logic              ysc [TAPS+1];

  cw_fir_seq #(.TAPS(TAPS)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .x_vld (x_vld),
    .acc_v (acc_v),
    .inj_v (inj_v)
  );

  assign xs[0]     = x_data;
  assign xsv[0]    = acc_v;
  assign ys[TAPS]  = '0;
  assign ysv[TAPS] = inj_v;
  assign ysc[TAPS] = 1'b1;

  for (genvar c = 0; c < TAPS; c++) begin : g_cell
    cw_fir_cell #(
      .DATA_W  (DATA_W),
      .ACC_W   (ACC_W),
      .IDX_W   (IDX_W),
      .COEF_ID (TAPS - 1 - c)
    ) u_cell (
      .clk       (clk),
      .rst       (rst),
      .coef_we   (coef_we),
      .coef_idx  (coef_idx),
      .coef_data (coef_data),
      .x_in      (xs[c]),
      .x_in_v    (xsv[c]),
      .y_in      (ys[c+1]),
      .y_in_v    (ysv[c+1]),
      .y_in_c    (ysc[c+1]),
      .x_out     (xs[c+1]),
      .x_out_v   (xsv[c+1]),
      .y_out     (ys[c]),
      .y_out_v   (ysv[c]),
      .y_out_c   (ysc[c])
    );
  end

  assign res_valid = ysv[0] & ysc[0];
  assign res_data  = ys[0];

  p_acc_space_r3: assert property (@(posedge clk) disable iff (rst)
    acc_v |=> !acc_v);
  p_res_space_r6: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  p_resp_r5: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(acc_v));
  p_tail_space_r3: assert property (@(posedge clk) disable iff (rst)
    xsv[TAPS] |=> (!xsv[TAPS] && $past(xs[TAPS]) == $past(xs[TAPS])));

endmodule

// File: tb/cw_fir_array_test.sv
`timescale 1ns/1ps
module cw_fir_array_test;
  localparam int TAPS   = 4;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 2;
  localparam int ACC_W  = 18;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              coef_we = 1'b0;
  logic [IDX_W-1:0]  coef_idx = '0;
  logic [DATA_W-1:0] coef_data = '0;
  logic              x_vld = 1'b0;
  logic [DATA_W-1:0] x_data = '0;
  logic              res_valid;
  logic [ACC_W-1:0]  res_data;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  int coef [TAPS];
  int hx [256];
  bit hv [256];

  always #2.5 clk = ~clk;

  cw_fir_array #(.TAPS(TAPS), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst(rst), .coef_we(coef_we), .coef_idx(coef_idx),
    .coef_data(coef_data), .x_vld(x_vld), .x_data(x_data),
    .res_valid(res_valid), .res_data(res_data)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; x_vld = 1'b0; coef_we = 1'b0;
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R1 valid in reset", res_valid, 0);
    rst = 1'b0;
    cyc = 0;
    for (int i = 0; i < TAPS; i++) coef[i] = 0;
    for (int i = 0; i < 256; i++) begin hv[i] = 1'b0; hx[i] = 0; end
  endtask

  // one clock: drive at negedge, check after the next posedge
  task automatic step(input bit v, input int xv, input string tag);
    longint exp;
    bit     full;
    int     s;
    x_vld  = v;
    x_data = DATA_W'(xv);
    @(posedge clk);
    @(negedge clk);
    coef_we = 1'b0;
    if (cyc % 2 == 0) begin
      s = cyc / 2;
      hv[s] = v;
      hx[s] = xv;
      full = (s >= TAPS - 1);
      exp = 0;
      if (full)
        for (int j = 0; j < TAPS; j++) begin
          if (!hv[s-TAPS+1+j]) full = 1'b0;
          exp += longint'(coef[j]) * longint'(hx[s-TAPS+1+j]);
        end
      if (full) begin
        chk(res_valid == 1'b1, "R5 result timing", res_valid, 1);
        chk(longint'($signed(res_data)) == exp, tag, longint'($signed(res_data)), exp);
      end else begin
        chk(res_valid == 1'b0, "R4 incomplete window", res_valid, 0);
      end
    end else begin
      chk(res_valid == 1'b0, "R6 odd cycle", res_valid, 0);
    end
    cyc++;
  endtask

  function automatic int cset(input int set, input int j);
    case (set)
      0: return j + 1;
      1: return (j == 0) ? -3 : (j == 1) ? 5 : (j == 2) ? 0 : 7;
      2: return -128;
      default: return (j == 0) ? 127 : (j == 1) ? -1 : (j == 2) ? 64 : -128;
    endcase
  endfunction

  function automatic int sample(input int pat, input int s);
    case (pat)
      0: return s - 20;
      1: return ((s * 37 + 11) % 256) - 128;
      2: return (s % 2 == 0) ? -128 : 127;
      default: return -128;
    endcase
  endfunction

  task automatic run(input int set, input int pat, input bit gaps, input bit junk,
                     input bit load, input string tag);
    do_reset();
    for (int j = 0; j < TAPS; j++) begin
      if (load) begin
        coef_we = 1'b1; coef_idx = IDX_W'(j); coef_data = DATA_W'(cset(set, j));
        coef[j] = cset(set, j);
      end
      step(1'b0, 0, tag);
    end
    for (int k = 0; k < 40; k++) begin
      step(!(gaps && (k % 7 == 3)), sample(pat, k), tag);
      step(junk, 99 - k, tag);
    end
  endtask

  initial begin
    // R1: cleared coefficients give zero results
    run(0, 1, 1'b0, 1'b0, 1'b0, "R1 cleared coef value");
    for (int set = 0; set < 4; set++)
      for (int pat = 0; pat < 4; pat++) begin
        string t;
        if (pat >= 2 || set == 2) t = "R7/R8 extreme value";
        else                      t = "R2/R8 filter value";
        run(set, pat, 1'b0, 1'b0, 1'b1, t);
      end
    run(1, 1, 1'b1, 1'b0, 1'b1, "R4/R2 gapped value");
    run(3, 2, 1'b1, 1'b0, 1'b1, "R4/R7 gapped extreme value");
    run(0, 0, 1'b0, 1'b1, 1'b1, "R3 odd junk ignored value");
    run(1, 1, 1'b1, 1'b1, 1'b1, "R3 odd junk gapped value");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL R5 watchdog: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule